// File: doc/BRIEF.md
# Serial Wiper Code Receiver

This block receives the setting of a digitally controlled resistor over a write-only three-wire serial link. A host raises a select line, presents one data bit per rising edge of a serial clock, and then lowers the select line. The block samples all three lines with its own, faster system clock, shifts the bits into a holding register and, when the select line falls, copies the holding register into the wiper code output. It also raises a one-cycle update strobe.

Each serial line passes through a synchronizer chain, and every edge decision is made in the system clock domain. The holding register is never cleared between frames. A short frame therefore merges with older bits, and a long frame keeps only its most recent bits. Both registers start at midscale after reset.

Top module: `wsr_wiper_top`

## Requirements
- R1: The select input `cs_i` is active high. Serial bits are shifted in only while it is high.
- R2: A data bit is captured on each rising edge of `sclk_i`. Falling edges, and changes of `sdi_i` while `sclk_i` stays high, do not alter the captured value.
- R3: The code is sent most significant bit first. The first of eight bits lands in bit 7 of `wiper_o` and the last in bit 0.
- R4: On a high-to-low transition of `cs_i`, the holding register is copied into `wiper_o`.
- R5: If a frame carries more than eight bits, only the final eight bits clocked in reach `wiper_o`.
- R6: A frame with fewer than eight bits (including zero) still commits on the fall of `cs_i`. Its n bits fill bits n-1..0, and the upper bits are the previous holding-register bits shifted up by n.
- R7: After a synchronous reset, `wiper_o` and the holding register both equal 0x80 and `upd_o` is low.
- R8: `upd_o` is high for exactly one system clock cycle per frame, in the cycle `wiper_o` takes its new value, and `wiper_o` never changes while `upd_o` is low.
- R9: A rising edge of `sclk_i` while `cs_i` is low leaves the holding register unchanged. A later zero-bit frame commits the old contents.
- R10: Counting from the system clock edge after `cs_i` is driven low, `upd_o` and the new `wiper_o` appear after the third rising edge of `clk_i` (two synchronizer stages plus one register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than four times the serial clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Serial select, active high, asynchronous to clk_i |
| sclk_i | input | 1 | Serial clock, asynchronous to clk_i |
| sdi_i | input | 1 | Serial data, most significant bit first |
| wiper_o | output | 8 | Committed wiper code |
| upd_o | output | 1 | One-cycle strobe when wiper_o is loaded |

## Verification
The embedded assertions check four rules on every cycle. A detected select fall loads the holding word on the next cycle, together with a strobe. Each qualified rising clock edge moves the sampled data bit into bit 0 and shifts the older bits up. Clock edges seen while select is low freeze the holding register. The strobe is never wider than one cycle and always accompanies a wiper change. The bench scenarios are the only place where the end-to-end bit ordering is shown. They also cover the overlong and short frames that merge with history, the three-cycle commit latency, and immunity to data changes while the clock is high. These properties need a model of whole frames, so the bench compares against a frame-level reference kept in the bench.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

    localparam int CODE_W     = 8;
    localparam int LINE_COUNT = 3;

    typedef logic [CODE_W-1:0] code_t;

    // order of the three serial lines inside the synchronizer vector
    typedef struct packed {
        logic sel;
        logic sck;
        logic dat;
    } lines_t;

    // edge events detected in the system clock domain
    typedef struct packed {
        logic sel_fall;
        logic sck_rise;
    } events_t;

    function automatic code_t midscale_code();
        code_t c;
        c = '0;
        c[CODE_W-1] = 1'b1;
        return c;
    endfunction

    function automatic code_t push_bit(code_t word, logic b);
        return {word[CODE_W-2:0], b};
    endfunction

endpackage

// File: rtl/wsr_sync.sv
module wsr_sync #(
    parameter int WIDTH = 3,
    parameter int DEPTH = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    localparam int LAST = DEPTH - 1;

    logic [WIDTH-1:0] chain [DEPTH];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int k = 0; k < DEPTH; k++) chain[k] <= '0;
            prev_q <= '0;
        end else begin
            chain[0] <= raw_i;
            for (int k = 1; k < DEPTH; k++) chain[k] <= chain[k-1];
            prev_q <= chain[LAST];
        end
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_edge
        assign level_o[b] = chain[LAST][b];
        assign rise_o[b]  = chain[LAST][b] & ~prev_q[b];
        assign fall_o[b]  = ~chain[LAST][b] & prev_q[b];
    end

endmodule

// File: rtl/wsr_shift.sv
module wsr_shift
    import wsr_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  lines_t  level_i,
    input  events_t ev_i,
    output code_t   word_o
);
    code_t word_q;

    // R1, R2: accept a bit only on a qualified rising clock edge
    always_ff @(posedge clk_i) begin
        if (rst_i)
            word_q <= midscale_code();
        else if (ev_i.sck_rise && level_i.sel)
            word_q <= push_bit(word_q, level_i.dat);
    end

    assign word_o = word_q;

    a_r2_bit_enters_lsb: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev_i.sck_rise && level_i.sel) |=>
            (word_q[0] == $past(level_i.dat)) &&
            (word_q[CODE_W-1:1] == $past(word_q[CODE_W-2:0])));

    a_r9_idle_edge_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        (!level_i.sel) |=> $stable(word_q));

endmodule

// File: rtl/wsr_commit.sv
module wsr_commit
    import wsr_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  events_t ev_i,
    input  code_t   word_i,
    output code_t   wiper_o,
    output logic    upd_o
);
    code_t wiper_q;
    logic  upd_q;

    // R4, R8: load on select fall, strobe in the same cycle
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wiper_q <= midscale_code();
            upd_q   <= 1'b0;
        end else begin
            upd_q <= ev_i.sel_fall;
            if (ev_i.sel_fall) wiper_q <= word_i;
        end
    end

    assign wiper_o = wiper_q;
    assign upd_o   = upd_q;

    a_r4_commit_on_fall: assert property (@(posedge clk_i) disable iff (rst_i)
        ev_i.sel_fall |=> (upd_q && wiper_q == $past(word_i)));

    a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_q |=> !upd_q);

    a_r8_change_has_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        !upd_q |-> $stable(wiper_q));

    a_r7_reset_midscale: assert property (@(posedge clk_i)
        rst_i |=> (wiper_q == midscale_code() && !upd_q));

endmodule

// File: rtl/wsr_wiper_top.sv
module wsr_wiper_top
    import wsr_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cs_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic [CODE_W-1:0] wiper_o,
    output logic              upd_o
);
    lines_t  raw_lines;
    lines_t  lvl_lines;
    lines_t  rise_lines;
    lines_t  fall_lines;
    events_t ev;
    code_t   word;
    code_t   wiper;

    logic [LINE_COUNT-1:0] lvl_vec;
    logic [LINE_COUNT-1:0] rise_vec;
    logic [LINE_COUNT-1:0] fall_vec;

    assign raw_lines.sel = cs_i;
    assign raw_lines.sck = sclk_i;
    assign raw_lines.dat = sdi_i;

    wsr_sync #(
        .WIDTH(LINE_COUNT),
        .DEPTH(SYNC_DEPTH)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .raw_i  (raw_lines),
        .level_o(lvl_vec),
        .rise_o (rise_vec),
        .fall_o (fall_vec)
    );

    assign lvl_lines  = lines_t'(lvl_vec);
    assign rise_lines = lines_t'(rise_vec);
    assign fall_lines = lines_t'(fall_vec);

    assign ev.sel_fall = fall_lines.sel;
    assign ev.sck_rise = rise_lines.sck;

    wsr_shift u_shift (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .level_i(lvl_lines),
        .ev_i   (ev),
        .word_o (word)
    );

    wsr_commit u_commit (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ev_i   (ev),
        .word_i (word),
        .wiper_o(wiper),
        .upd_o  (upd_o)
    );

    assign wiper_o = wiper;

endmodule

// File: tb/sim_wsr_wiper_top.sv
module sim_wsr_wiper_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic [7:0] wiper;
    logic       upd;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int cycles = 0;
    bit done   = 1'b0;
    bit mon_on = 1'b0;

    logic [7:0] exp_shift = 8'h80;
    logic [7:0] exp_wiper = 8'h80;

    always #5 clk = ~clk;

    wsr_wiper_top u0 (
        .clk_i  (clk),
        .rst_i  (rst),
        .cs_i   (cs),
        .sclk_i (sclk),
        .sdi_i  (sdi),
        .wiper_o(wiper),
        .upd_o  (upd)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] model_push(input logic [7:0] w, input logic b);
        return {w[6:0], b};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(1'b0, "watchdog", cycles, 150000);
            finish_run();
        end
    end

    // R8: continuous strobe and change monitor
    logic [7:0] last_wiper = 8'h80;
    logic       last_upd   = 1'b0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (upd) begin
                pulses++;
                check(!last_upd, "R8 strobe wider than one cycle", 1, 0);
                check(wiper == exp_wiper, "R8 wiper at strobe", wiper, exp_wiper);
            end else if (wiper != last_wiper) begin
                check(1'b0, "R8 wiper changed without strobe", wiper, last_wiper);
            end
        end
        last_wiper = wiper;
        last_upd   = upd;
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one serial bit: rising edge mid-bit, data disturbed while clock high (R2)
    task automatic send_bit(input logic b, input bit active);
        @(negedge clk);
        sdi = b;
        sclk = 1'b0;
        wait_clk(4);
        sclk = 1'b1;
        if (active) exp_shift = model_push(exp_shift, b);
        wait_clk(2);
        sdi = ~b;
        wait_clk(2);
        sclk = 1'b0;
    endtask

    // frame of n bits taken from the low n bits of val, MSB first
    task automatic send_frame(input logic [15:0] val, input int n, input string tag);
        int p0;
        @(negedge clk);
        cs = 1'b1;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) send_bit(val[i], 1'b1);
        wait_clk(4);
        p0 = pulses;
        cs = 1'b0;
        exp_wiper = exp_shift;
        // R10: two edges of synchronizer, then the register
        @(negedge clk);
        @(negedge clk);
        check(upd == 1'b0, {"R10 early strobe ", tag}, upd, 0);
        @(negedge clk);
        check(upd == 1'b1, {"R10 strobe at third edge ", tag}, upd, 1);
        check(wiper == exp_wiper, {"R4 commit ", tag}, wiper, exp_wiper);
        wait_clk(6);
        check(pulses - p0 == 1, {"R8 one pulse per frame ", tag}, pulses - p0, 1);
        check(wiper == exp_wiper, {"R4 hold after frame ", tag}, wiper, exp_wiper);
    endtask

    initial begin
        int seed_dummy;
        logic [15:0] rv;
        int rn;
        seed_dummy = $urandom(32'h5eed_1234);

        wait_clk(4);
        @(negedge clk);
        rst = 1'b0;
        wait_clk(2);
        // R7 reset state
        check(wiper == 8'h80, "R7 reset wiper", wiper, 8'h80);
        check(upd == 1'b0, "R7 reset strobe", upd, 0);
        mon_on = 1'b1;

        // R6, R7: empty frame after reset commits midscale holding register
        send_frame(16'h0, 0, "R6 empty after reset");
        check(wiper == 8'h80, "R7 holding reg midscale", wiper, 8'h80);

        // R3, R2: plain byte, MSB first
        send_frame(16'h00A5, 8, "R3 0xA5");
        check(wiper == 8'hA5, "R3 bit order 0xA5", wiper, 8'hA5);
        send_frame(16'h003C, 8, "R2 0x3C");
        check(wiper == 8'h3C, "R2 rising edge capture", wiper, 8'h3C);
        send_frame(16'h0000, 8, "R4 zero");
        send_frame(16'h00FF, 8, "R4 full");

        // R5: twelve bits, only last eight kept
        send_frame(16'h0ABC, 12, "R5 long");
        check(wiper == 8'hBC, "R5 last eight bits", wiper, 8'hBC);

        // R6: three bits merge with history 0xBC -> 0xE5
        send_frame(16'h0005, 3, "R6 short");
        check(wiper == 8'hE5, "R6 short frame merge", wiper, 8'hE5);

        // R9, R1: clock pulses with select low change nothing
        for (int i = 0; i < 5; i++) send_bit(1'(i & 1), 1'b0);
        wait_clk(6);
        check(wiper == 8'hE5, "R1 no commit while select low", wiper, 8'hE5);
        send_frame(16'h0, 0, "R9 empty after idle clocks");
        check(wiper == 8'hE5, "R9 holding reg unchanged", wiper, 8'hE5);

        // random frames
        for (int f = 0; f < 24; f++) begin
            rv = 16'($urandom);
            rn = 1 + int'($urandom % 12);
            send_frame(rv, rn, "random");
        end

        // R7: reset mid-run returns to midscale
        @(negedge clk);
        rst = 1'b1;
        mon_on = 1'b0;
        wait_clk(3);
        rst = 1'b0;
        exp_shift = 8'h80;
        exp_wiper = 8'h80;
        wait_clk(2);
        check(wiper == 8'h80, "R7 second reset", wiper, 8'h80);
        mon_on = 1'b1;
        send_frame(16'h0001, 1, "R6 one bit after reset");
        check(wiper == 8'h01, "R6 one bit merge", wiper, 8'h01);

        wait_clk(10);
        finish_run();
    end

endmodule